// File: doc/BRIEF.md
# Song Event Sequencer with Note Allocation

This block walks through one song held in an external event memory and turns its contents into note-start commands for a bank of parallel note players. Each 18-bit memory word is one of two kinds. A schedule word starts a note at the current instant. An advance word moves musical time forward by a number of 48th-note ticks. Several schedule words placed back to back start together, and the advance word that follows lets them sound while the tick count runs down. Because the time base is the 48th note, both sixteenth notes and triplets land on whole ticks.

The sequencer reads one word per clock while it is fetching. When it meets a non-zero advance, it waits for that many ticks before it reads again. For each player it keeps a count of the remaining duration, so it always knows which players are free. A new note goes to the lowest-numbered free player, chosen by a combinational priority chain. If no player is free, the note is dropped and a sticky overflow flag is raised. After the last word of the selected song has been handled, the block stops and raises done.

Waveform synthesis, mixing and tempo generation are outside this block. The tick arrives as an input, and the players only consume the load strobes.

Top module: `song_sequencer`

## Requirements
- R1: A word whose bit 17 is 0 is a schedule word. Its fields are note in bits 16:11, duration in bits 10:5, amplitude in bits 4:2 and voice in bits 1:0. When such a word raises a load strobe, the strobe is combinational in the fetch cycle, and ld_note, ld_dur, ld_amp and ld_voice carry those four fields in the same cycle.
- R2: A word whose bit 17 is 1 is an advance word, and bits 16:11 give its tick count N. When N is greater than 0, the address moves to the next word and then holds there. The fetch of that next word happens in the clock cycle after the Nth tick that is seen while play_en is high.
- R3: When a schedule word is fetched while every player is busy, no strobe is raised. overflow becomes 1 in the next cycle and stays 1 until reset.
- R4: ld_strobe is one-hot or zero. A schedule word goes to the lowest-indexed player whose busy bit is 0.
- R5: While fetching, one word is consumed per clock. Consecutive schedule words therefore raise strobes on consecutive cycles, with no tick needed between them.
- R6: Each player has a remaining-duration count. A strobe loads it with ld_dur, each tick decrements it while it is non-zero, and busy is 1 exactly while it is non-zero. A load takes effect in the cycle after the strobe. A note of duration 0 leaves its player free.
- R7: An advance word with count 0 moves on to the next word in the next clock, without waiting for a tick.
- R8: After word SONG_LEN-1 has been handled, including any wait it requests, done rises in the next cycle. While done is 1, no strobes are raised and the address stays put. done stays 1 until play_en is low. The block then returns to idle.
- R9: While play_en is low, no word is fetched, no strobe is raised, the address does not change and wait ticks are not counted. The player duration counts keep decrementing on ticks.
- R10: rd_addr is {song, position}. The song is latched from song_sel when play_en is seen high in idle. Any later change of song_sel has no effect until the next start. Playback begins at position 0.
- R11: During and right after reset, rd_addr is 0, ld_strobe is 0, busy is 0, overflow is 0 and done is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| song_sel | input | SONG_SEL_W (2) | Song to play, latched at start |
| play_en | input | 1 | Run (1) or pause (0); falling after done returns the block to idle |
| tick | input | 1 | One-cycle pulse per 48th note |
| rd_data | input | 18 | Event word at rd_addr (combinational read) |
| rd_addr | output | SONG_SEL_W+log2(SONG_LEN) (9) | Event memory address |
| ld_strobe | output | NUM_PLAYERS (4) | Per-player note-start strobe |
| ld_note | output | 6 | Note number for the strobed player |
| ld_dur | output | 6 | Duration in ticks |
| ld_amp | output | 3 | Amplitude |
| ld_voice | output | 2 | Voice |
| busy | output | NUM_PLAYERS (4) | Player still sounding |
| overflow | output | 1 | Sticky: a note was dropped |
| done | output | 1 | Song finished |

## Verification
The bench builds the block with its defaults: four players, four songs of 128 words. Four players is one more than the minimum polyphony, so a directed chord of four long notes followed by more schedule words fills every player and makes the drop path reachable. Full 128-word songs make the end-of-song condition reachable, both after a schedule word and after a final advance that still has to wait. Random songs mix zero and non-zero advances. Random pauses and mid-song changes of song_sel exercise the pause and latch rules.

// File: rtl/seq_pkg.sv
package seq_pkg;
   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_READ = 2'd1,
      SQ_WAIT = 2'd2,
      SQ_DONE = 2'd3
   } sq_state_t;
endpackage

// File: rtl/seq_alloc.sv
// Lowest-index-first free player picker, purely combinational.
module seq_alloc #(
   parameter int NUM_PLAYERS = 4
) (
   input  logic [NUM_PLAYERS-1:0] busy,
   output logic [NUM_PLAYERS-1:0] grant,
   output logic                   any_free
);
   logic [NUM_PLAYERS:0] taken;
   assign taken[0] = 1'b0;

   for (genvar g = 0; g < NUM_PLAYERS; g++) begin : g_chain
      assign grant[g]   = ~busy[g] & ~taken[g];
      assign taken[g+1] = taken[g] | ~busy[g];
   end

   assign any_free = taken[NUM_PLAYERS];
endmodule

// File: rtl/seq_voice_timer.sv
// Remaining-duration counter for one note player.
module seq_voice_timer #(
   parameter int DUR_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [DUR_W-1:0] load_dur,
   input  logic             tick,
   output logic             busy
);
   logic [DUR_W-1:0] remain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (load) begin
         remain_q <= load_dur;
      end else if (tick && remain_q != '0) begin
         remain_q <= remain_q - 1'b1;
      end
   end

   assign busy = remain_q != '0;
endmodule

// File: rtl/seq_ctrl.sv
// Word walker: fetch, tick wait, end-of-song and pause handling.
module seq_ctrl
   import seq_pkg::*;
#(
   parameter int SONG_LEN   = 128,
   parameter int SONG_SEL_W = 2,
   parameter int CNT_W      = 6,
   localparam int POS_W     = $clog2(SONG_LEN),
   localparam int ADDR_W    = SONG_SEL_W + POS_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  play_en,
   input  logic                  tick,
   input  logic [SONG_SEL_W-1:0] song_sel,
   input  logic                  word_adv,
   input  logic [CNT_W-1:0]      adv_cnt,
   output logic [ADDR_W-1:0]     rd_addr,
   output logic                  fetch,
   output logic                  done
);
   localparam int IDX_W = POS_W + 1;

   sq_state_t             st_q;
   logic [IDX_W-1:0]      idx_q;
   logic [SONG_SEL_W-1:0] song_q;
   logic [CNT_W-1:0]      wait_q;
   logic                  last_word, past_end, must_wait;

   assign last_word = idx_q == IDX_W'(SONG_LEN - 1);
   assign past_end  = idx_q == IDX_W'(SONG_LEN);
   assign must_wait = word_adv && (adv_cnt != '0);

   assign fetch   = (st_q == SQ_READ) && play_en;
   assign done    = st_q == SQ_DONE;
   assign rd_addr = {song_q, idx_q[POS_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         idx_q  <= '0;
         song_q <= '0;
         wait_q <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (play_en) begin
               song_q <= song_sel;
               idx_q  <= '0;
               st_q   <= SQ_READ;
            end
            SQ_READ: if (play_en) begin
               idx_q <= idx_q + 1'b1;
               if (must_wait) begin
                  wait_q <= adv_cnt;
                  st_q   <= SQ_WAIT;
               end else if (last_word) begin
                  st_q <= SQ_DONE;
               end
            end
            SQ_WAIT: if (play_en && tick) begin
               wait_q <= wait_q - 1'b1;
               if (wait_q == CNT_W'(1)) st_q <= past_end ? SQ_DONE : SQ_READ;
            end
            SQ_DONE: if (!play_en) begin
               idx_q <= '0;
               st_q  <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/song_sequencer.sv
module song_sequencer #(
   parameter int NUM_PLAYERS = 4,
   parameter int SONG_LEN    = 128,
   parameter int SONG_SEL_W  = 2,
   parameter int NOTE_W      = 6,
   parameter int DUR_W       = 6,
   parameter int AMP_W       = 3,
   parameter int VOICE_W     = 2,
   localparam int WORD_W     = 1 + NOTE_W + DUR_W + AMP_W + VOICE_W,
   localparam int ADDR_W     = SONG_SEL_W + $clog2(SONG_LEN)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [SONG_SEL_W-1:0]  song_sel,
   input  logic                   play_en,
   input  logic                   tick,
   input  logic [WORD_W-1:0]      rd_data,
   output logic [ADDR_W-1:0]      rd_addr,
   output logic [NUM_PLAYERS-1:0] ld_strobe,
   output logic [NOTE_W-1:0]      ld_note,
   output logic [DUR_W-1:0]       ld_dur,
   output logic [AMP_W-1:0]       ld_amp,
   output logic [VOICE_W-1:0]     ld_voice,
   output logic [NUM_PLAYERS-1:0] busy,
   output logic                   overflow,
   output logic                   done
);
   localparam int AMP_LSB  = VOICE_W;
   localparam int DUR_LSB  = AMP_LSB + AMP_W;
   localparam int NOTE_LSB = DUR_LSB + DUR_W;
   localparam int KIND_BIT = WORD_W - 1;

   if (NUM_PLAYERS < 3) begin : g_chk_players
      $error("song_sequencer: NUM_PLAYERS must be at least 3");
   end
   if (SONG_LEN < 2 || (SONG_LEN & (SONG_LEN - 1)) != 0) begin : g_chk_len
      $error("song_sequencer: SONG_LEN must be a power of two");
   end

   logic                   word_adv, fetch, any_free, sched;
   logic [NUM_PLAYERS-1:0] grant;

   assign word_adv = rd_data[KIND_BIT];
   assign ld_note  = rd_data[NOTE_LSB +: NOTE_W];
   assign ld_dur   = rd_data[DUR_LSB +: DUR_W];
   assign ld_amp   = rd_data[AMP_LSB +: AMP_W];
   assign ld_voice = rd_data[0 +: VOICE_W];

   seq_ctrl #(
      .SONG_LEN   (SONG_LEN),
      .SONG_SEL_W (SONG_SEL_W),
      .CNT_W      (NOTE_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .play_en  (play_en),
      .tick     (tick),
      .song_sel (song_sel),
      .word_adv (word_adv),
      .adv_cnt  (ld_note),
      .rd_addr  (rd_addr),
      .fetch    (fetch),
      .done     (done)
   );

   seq_alloc #(.NUM_PLAYERS(NUM_PLAYERS)) u_alloc (
      .busy     (busy),
      .grant    (grant),
      .any_free (any_free)
   );

   assign sched     = fetch && !word_adv;
   assign ld_strobe = sched ? grant : '0;

   for (genvar p = 0; p < NUM_PLAYERS; p++) begin : g_player
      seq_voice_timer #(.DUR_W(DUR_W)) u_timer (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ld_strobe[p]),
         .load_dur (ld_dur),
         .tick     (tick),
         .busy     (busy[p])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                overflow <= 1'b0;
      else if (sched && !any_free) overflow <= 1'b1;
   end
endmodule

// File: rtl/seq_checker.sv
module seq_checker #(
   parameter int NUM_PLAYERS = 4,
   parameter int DUR_W       = 6,
   parameter int ADDR_W      = 9
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   play_en,
   input logic [ADDR_W-1:0]      rd_addr,
   input logic [NUM_PLAYERS-1:0] ld_strobe,
   input logic [DUR_W-1:0]       ld_dur,
   input logic [NUM_PLAYERS-1:0] busy,
   input logic                   overflow,
   input logic                   done
);
   assert_strobe_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ld_strobe));

   assert_strobe_to_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_strobe & busy) == '0);

   assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |=> overflow);

   assert_load_makes_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ((ld_strobe != '0) && (ld_dur != '0)) |=> ((busy & $past(ld_strobe)) != '0));

   assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (ld_strobe == '0));

   assert_pause_no_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !play_en |-> (ld_strobe == '0));

   assert_pause_addr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !play_en |=> $stable(rd_addr));
endmodule

bind song_sequencer seq_checker #(
   .NUM_PLAYERS (NUM_PLAYERS),
   .DUR_W       (DUR_W),
   .ADDR_W      (ADDR_W)
) u_seq_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .play_en   (play_en),
   .rd_addr   (rd_addr),
   .ld_strobe (ld_strobe),
   .ld_dur    (ld_dur),
   .busy      (busy),
   .overflow  (overflow),
   .done      (done)
);

// File: tb/tb_song_sequencer.sv
module tb_song_sequencer;
   localparam int NP = 4;
   localparam int LEN = 128;
   localparam int SONGS = 4;

   logic clk = 1'b0, rst_n = 1'b0, play_en = 1'b0, tick = 1'b0;
   logic [1:0]    song_sel = '0;
   logic [17:0]   rd_data;
   logic [8:0]    rd_addr;
   logic [NP-1:0] ld_strobe, busy;
   logic [5:0]    ld_note, ld_dur;
   logic [2:0]    ld_amp;
   logic [1:0]    ld_voice;
   logic          overflow, done;

   logic [17:0] mem [0:SONGS*LEN-1];
   assign rd_data = mem[rd_addr];

   always #2 clk = ~clk;

   song_sequencer dut (
      .clk(clk), .rst_n(rst_n), .song_sel(song_sel), .play_en(play_en), .tick(tick),
      .rd_data(rd_data), .rd_addr(rd_addr), .ld_strobe(ld_strobe), .ld_note(ld_note),
      .ld_dur(ld_dur), .ld_amp(ld_amp), .ld_voice(ld_voice), .busy(busy),
      .overflow(overflow), .done(done)
   );

   int n_cmp = 0, n_bad = 0, cyc = 0;
   int m_st = 0, m_idx = 0, m_song = 0, m_wait = 0, m_ovf = 0, m_zero = 0;
   int m_rem [NP];
   bit wd = 0;

   function automatic logic [17:0] w_sched(int n, int d, int a, int v);
      return {1'b0, 6'(n), 6'(d), 3'(a), 2'(v)};
   endfunction
   function automatic logic [17:0] w_adv(int c);
      return {1'b1, 6'(c), 11'd0};
   endfunction
   function automatic logic [17:0] w_rand();
      if ($urandom % 10 < 7)
         return w_sched($urandom % 64, $urandom % 16, $urandom % 8, $urandom % 4);
      return w_adv($urandom % 5);
   endfunction

   task automatic chk(string req, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
      end
   endtask

   task automatic step(bit r, bit pe, int ss, bit tk);
      int a, pick, ebusy, estr;
      logic [17:0] w;
      bit fetch, sched;
      string atag;
      @(negedge clk);
      rst_n = r; play_en = pe; song_sel = 2'(ss); tick = tk;
      #1;
      cyc++;
      if (!r) begin
         m_st = 0; m_idx = 0; m_song = 0; m_wait = 0; m_ovf = 0; m_zero = 0;
         foreach (m_rem[p]) m_rem[p] = 0;
         chk("R11 addr", rd_addr, 0);
         chk("R11 strobe", ld_strobe, 0);
         chk("R11 busy", busy, 0);
         chk("R11 overflow", overflow, 0);
         chk("R11 done", done, 0);
         return;
      end
      a = m_song * LEN + (m_idx % LEN);
      w = mem[a];
      fetch = (m_st == 1) && pe;
      sched = fetch && !w[17];
      pick = -1;
      for (int p = 0; p < NP; p++) if (m_rem[p] == 0 && pick < 0) pick = p;
      estr = (sched && pick >= 0) ? (1 << pick) : 0;
      ebusy = 0;
      for (int p = 0; p < NP; p++) if (m_rem[p] != 0) ebusy |= (1 << p);
      if (!pe && m_st != 0) atag = "R9 addr held";
      else if (m_zero != 0) atag = "R7 addr after zero advance";
      else if (m_st == 1)   atag = "R5 addr fetch";
      else if (m_st == 2)   atag = "R2 addr during wait";
      else if (m_st == 3)   atag = "R8 addr when done";
      else                  atag = "R10 addr idle";
      chk(atag, rd_addr, a);
      chk("R4 strobe", ld_strobe, estr);
      if (estr != 0) begin
         chk("R1 note", ld_note, w[16:11]);
         chk("R1 dur", ld_dur, w[10:5]);
         chk("R1 amp", ld_amp, w[4:2]);
         chk("R1 voice", ld_voice, w[1:0]);
      end
      chk(pe ? "R6 busy" : "R9 busy while paused", busy, ebusy);
      chk("R3 overflow", overflow, m_ovf);
      chk("R8 done", done, m_st == 3);
      // advance the reference model across the coming edge
      for (int p = 0; p < NP; p++) begin
         if (estr[p]) m_rem[p] = w[10:5];
         else if (tk && m_rem[p] > 0) m_rem[p]--;
      end
      if (sched && pick < 0) m_ovf = 1;
      m_zero = 0;
      case (m_st)
         0: if (pe) begin m_song = ss; m_idx = 0; m_st = 1; end
         1: if (pe) begin
               m_idx++;
               if (w[17] && w[16:11] != 0) begin m_wait = w[16:11]; m_st = 2; end
               else if (m_idx == LEN) m_st = 3;
               if (w[17] && w[16:11] == 0 && m_st == 1) m_zero = 1;
            end
         2: if (pe && tk) begin
               m_wait--;
               if (m_wait == 0) m_st = (m_idx == LEN) ? 3 : 1;
            end
         default: if (!pe) begin m_idx = 0; m_st = 0; end
      endcase
   endtask

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < SONGS * LEN; i++) mem[i] = w_rand();
      // song 0: four long notes together, then more than the players can take
      mem[0] = w_sched(10, 40, 3, 1);
      mem[1] = w_sched(12, 40, 5, 2);
      mem[2] = w_sched(14, 40, 7, 3);
      mem[3] = w_adv(2);
      mem[4] = w_sched(20, 40, 1, 0);
      mem[5] = w_sched(21, 9, 2, 1);
      mem[6] = w_sched(22, 9, 4, 2);
      mem[7] = w_adv(0);
      mem[8] = w_sched(30, 0, 6, 3);
      mem[9] = w_adv(0);
      mem[LEN-1] = w_adv(3);
      mem[2*LEN-1] = w_sched(5, 2, 1, 1);

      repeat (3) step(0, 0, 0, 0);
      for (int s = 0; s < SONGS && !wd; s++) begin
         while (m_st != 3 && !wd) begin
            bit pe = ($urandom % 16) != 0;
            int ss = (m_st == 0) ? s : (($urandom % 6 == 0) ? int'($urandom % 4) : s);
            step(1, pe, ss, ($urandom % 4) == 0);
            if (cyc > 150000) wd = 1;
         end
         repeat (4) step(1, 1, s ^ 1, ($urandom % 4) == 0);
         if (s == 0) chk("R3 overflow raised by song 0", overflow, 1);
         chk("R8 done held while play_en high", done, 1);
         repeat (3) step(1, 0, s, ($urandom % 4) == 0);
         chk("R8 back to idle after play_en low", done, 0);
      end
      if (wd) begin
         n_cmp++; n_bad++;
         $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
      end
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(4 * 190000);
      n_cmp++; n_bad++;
      $display("FAIL R8 hung run actual=%0d expected=%0d", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule